// File: doc/BRIEF.md
# Half-Duplex Mode-0 Serial Slave Front End

This block is the serial entry point of a register-access core. A host drives a chip-select line, a serial clock that rests low, and a serial data line. The block samples those three wires into the system clock domain, frames the incoming bits into bytes most-significant bit first, and passes each complete byte to the core with a one-cycle strobe. The first byte after chip select falls is flagged as the command byte. Partial bytes are never delivered.

Once the core has decoded a read command it raises a read-phase level. At each byte boundary the block then takes a byte from a one-entry holding register that the core fills through a request/load handshake. It places the top bit on the serial output before the host's first sampling edge and moves to the next bit on each falling serial clock edge. While it drives read data, the output-enable is high and serial input is not assembled into bytes. At all other times the output-enable is low, so the pin can be tri-stated. If the holding register is empty when a read byte starts, zeros are shifted out and a sticky underrun flag is raised until the next chip-select fall.

Top module: `spi_m0_slave`

## Requirements
- R1: Serial input is sampled on rising serial clock edges while chip select is low. Each group of 8 rising edges yields one byte, with the first sampled bit in bit 7. That byte appears on `rx_byte` together with a single-cycle `rx_valid` pulse.
- R2: Any number of bytes may follow one another under one chip-select-low period. `rx_first` is 1 only for the first complete byte after chip select falls and 0 for later bytes.
- R3: When chip select rises, framing returns to bit 0. A byte with fewer than 8 rising edges before that rise produces no `rx_valid`, and the next transfer starts a fresh byte flagged as first.
- R4: `sdo_en` is 0 out of reset, while chip select is high, and during every byte that is not a read byte.
- R5: When `rd_phase` is high at a byte boundary with the serial clock low, the block drives `sdo_en` high and presents bit 7 of the transmit byte on `sdo` before the byte's first rising edge. Each later bit appears after a falling edge, most significant first. Both `sdo_en` and the loaded byte are dropped at the byte's 8th rising edge.
- R6: While a read byte is being driven, rising edges with any serial input value produce no `rx_valid`.
- R7: `tx_req` is high while chip select is low, `rd_phase` is high and the holding register is empty. A one-cycle `tx_load` stores `tx_data` into the holding register and drops `tx_req` on the next cycle.
- R8: A read byte that starts with an empty holding register is shifted out as 8'h00 and sets `underrun`. The flag stays set through chip-select high and is cleared by the next chip-select fall.
- R9: Out of reset `rx_valid`, `tx_req`, `underrun`, `sdo` and `sdo_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from host, active low |
| sck | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Output-enable for the `sdo` pad driver |
| rx_byte | output | 8 | Last completed receive byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_first | output | 1 | Marks `rx_byte` as the command byte |
| rd_phase | input | 1 | Core level: current bytes are read bytes |
| tx_req | output | 1 | Holding register empty during a read phase |
| tx_load | input | 1 | Core strobe writing `tx_data` into the holding register |
| tx_data | input | 8 | Transmit byte from the core |
| underrun | output | 1 | Sticky: a read byte started with no data loaded |

## Verification
The hardest case to reach is the handover at the end of the command byte. The core's read-phase decision, the holding-register load and the first serial-clock fall all fall within a few system cycles of one another, and the top bit must already be valid at the next rising edge. The bench acts as the core. It reacts to the command strobe with `rd_phase` and answers `tx_req` with loads, so this race happens at the real ratio of serial to system clock. A starvation switch withholds the loads to produce the underrun path. While read bytes are shifted out, the bench toggles the serial input so that any leaked receive strobe would show.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // append one sampled bit at the bottom, MSB leaves first
  function automatic byte_t shift_in(byte_t v, logic b);
    return {v[BYTE_W-2:0], b};
  endfunction

  function automatic byte_t shift_out(byte_t v);
    return {v[BYTE_W-2:0], 1'b0};
  endfunction

  function automatic logic is_last(cnt_t c);
    return c == cnt_t'(BYTE_W - 1);
  endfunction
endpackage

// File: rtl/spi_m0_sync.sv
module spi_m0_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_m0_rx.sv
module spi_m0_rx
  import spi_m0_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_high,
  input  logic  cs_fall,
  input  logic  sck_rise,
  input  logic  sdi_s,
  input  logic  tx_drv,
  output logic  byte_end,
  output logic  at_boundary,
  output byte_t rx_byte,
  output logic  rx_valid,
  output logic  rx_first
);
  cnt_t  bcnt;
  byte_t shreg;
  logic  first_q;

  assign byte_end    = sck_rise && !cs_high && is_last(bcnt);
  assign at_boundary = (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0; shreg <= '0; first_q <= 1'b0;
      rx_byte <= '0; rx_valid <= 1'b0; rx_first <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_fall) first_q <= 1'b1;
      if (cs_high) begin
        bcnt  <= '0;
        shreg <= '0;
      end else if (sck_rise) begin
        bcnt <= bcnt + 1'b1;
        if (!tx_drv) shreg <= shift_in(shreg, sdi_s);
        if (is_last(bcnt)) begin
          first_q <= 1'b0;
          if (!tx_drv) begin
            rx_valid <= 1'b1;
            rx_byte  <= shift_in(shreg, sdi_s);
            rx_first <= first_q;
          end
        end
      end
    end
  end

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_frame_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> at_boundary);
endmodule

// File: rtl/spi_m0_tx.sv
module spi_m0_tx
  import spi_m0_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_high,
  input  logic  cs_fall,
  input  logic  sck_lvl,
  input  logic  sck_fall,
  input  logic  byte_end,
  input  logic  at_boundary,
  input  logic  rd_phase,
  input  logic  tx_load,
  input  byte_t tx_data,
  output logic  tx_drv,
  output logic  sdo_bit,
  output logic  tx_req,
  output logic  underrun
);
  byte_t shreg, hold;
  logic  hold_v, load_evt;

  assign load_evt = !cs_high && rd_phase && at_boundary && !sck_lvl && !tx_drv;
  assign tx_req   = !cs_high && rd_phase && !hold_v;
  assign sdo_bit  = shreg[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_drv <= 1'b0; shreg <= '0; hold <= '0; hold_v <= 1'b0;
    end else if (cs_high) begin
      tx_drv <= 1'b0; shreg <= '0; hold_v <= 1'b0;
    end else begin
      if (byte_end) begin
        tx_drv <= 1'b0;
      end else if (load_evt) begin
        tx_drv <= 1'b1;
        shreg  <= hold_v ? hold : '0;
      end else if (tx_drv && sck_fall) begin
        shreg <= shift_out(shreg);
      end
      if (tx_load) begin
        hold   <= tx_data;
        hold_v <= 1'b1;
      end else if (load_evt) begin
        hold_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   underrun <= 1'b0;
    else if (cs_fall)             underrun <= 1'b0;
    else if (load_evt && !hold_v) underrun <= 1'b1;
  end

  p_release_on_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !tx_drv);
  p_change_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drv && $past(tx_drv) && !$past(sck_fall)) |-> $stable(sdo_bit));
  p_load_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !cs_high) |=> !tx_req);
  p_underrun_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !underrun);
endmodule

// File: rtl/spi_m0_slave.sv
module spi_m0_slave
  import spi_m0_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_first,
  input  logic              rd_phase,
  output logic              tx_req,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              underrun
);
  logic cs_s, sck_s, sdi_s, cs_q, sck_q;
  logic cs_fall, sck_rise, sck_fall;
  logic byte_end, at_boundary, tx_drv, sdo_bit;

  spi_m0_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sdi, sck, cs_n}), .q({sdi_s, sck_s, cs_s}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cs_q <= 1'b1; sck_q <= 1'b0; end
    else        begin cs_q <= cs_s; sck_q <= sck_s; end
  end

  assign cs_fall  = !cs_s && cs_q;
  assign sck_rise = sck_s && !sck_q;
  assign sck_fall = !sck_s && sck_q;

  spi_m0_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_high(cs_s), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sdi_s(sdi_s), .tx_drv(tx_drv),
    .byte_end(byte_end), .at_boundary(at_boundary),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_first(rx_first));

  spi_m0_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_high(cs_s), .cs_fall(cs_fall),
    .sck_lvl(sck_s), .sck_fall(sck_fall), .byte_end(byte_end),
    .at_boundary(at_boundary), .rd_phase(rd_phase), .tx_load(tx_load),
    .tx_data(tx_data), .tx_drv(tx_drv), .sdo_bit(sdo_bit),
    .tx_req(tx_req), .underrun(underrun));

  assign sdo_en = tx_drv;
  assign sdo    = tx_drv && sdo_bit;

  p_no_rx_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && tx_drv) |=> !rx_valid);
  p_first_only_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first) |-> !cs_s);
endmodule

// File: tb/spi_m0_slave_test.sv
module spi_m0_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en, rx_valid, rx_first, tx_req, underrun;
  logic [7:0] rx_byte;
  logic rd_phase, tx_load;
  logic [7:0] tx_data;

  int compared = 0, mismatched = 0;
  bit starve = 0, done = 0;
  logic [8:0] exp_rx[$];
  logic [7:0] exp_tx[$];
  logic [7:0] seed;

  always #2 clk = ~clk;

  spi_m0_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_first(rx_first), .rd_phase(rd_phase), .tx_req(tx_req),
    .tx_load(tx_load), .tx_data(tx_data), .underrun(underrun));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural core: a command with bit 7 set opens a read phase
  always @(negedge clk) begin
    if (!rst_n || cs_n) begin
      rd_phase <= 1'b0; tx_load <= 1'b0; tx_data <= 8'h00; seed <= 8'h5A;
    end else begin
      if (rx_valid && rx_first && rx_byte[7]) rd_phase <= 1'b1;
      if (tx_req && !tx_load && !starve) begin
        tx_load <= 1'b1; tx_data <= seed;
        exp_tx.push_back(seed);
        seed <= {seed[6:0], seed[7] ^ seed[5]} + 8'h13;
      end else tx_load <= 1'b0;
    end
  end

  // receive monitor, every clock
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0)
        check(0, rd_phase ? "R6" : "R3", {23'd0, rx_first, rx_byte}, 32'h0);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        check({rx_first, rx_byte} == e, "R1/R2 byte", {23'd0, rx_first, rx_byte}, {23'd0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_begin();
    cs_n = 1'b0; wait_clk(4);
  endtask

  task automatic spi_end();
    wait_clk(4); cs_n = 1'b1; wait_clk(8);
    exp_tx.delete();
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int nbits,
                          output logic [7:0] got, output bit en_all, output bit en_any);
    got = 8'h00; en_all = 1; en_any = 0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sdi = mo[i];
      wait_clk(4);
      got[i] = sdo; en_all &= sdo_en; en_any |= sdo_en;
      sck = 1'b1; wait_clk(4); sck = 1'b0;
    end
  endtask

  task automatic write_byte(input logic [7:0] b, input bit first);
    logic [7:0] g; bit ea, en;
    exp_rx.push_back({first, b});
    spi_bits(b, 8, g, ea, en);
    check(!en, "R4 no drive on write byte", en, 0);
  endtask

  task automatic read_byte(input logic [7:0] noise);
    logic [7:0] g, e; bit ea, en;
    spi_bits(noise, 8, g, ea, en);
    e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'h00;
    if (starve) e = 8'h00;
    check(ea, "R5 drive during read byte", ea, 1);
    check(g == e, starve ? "R8 zeros on underrun" : "R5 read data", g, e);
  endtask

  initial begin
    logic [7:0] g; bit ea, en;
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    check(!sdo_en && !sdo, "R9 reset outputs", {sdo_en, sdo}, 0);
    check(!rx_valid && !tx_req && !underrun, "R9 reset flags", {rx_valid, tx_req, underrun}, 0);

    spi_begin(); write_byte(8'h12, 1); write_byte(8'h34, 0); write_byte(8'h56, 0); spi_end();
    check(exp_rx.size() == 0, "R2 all bytes delivered", exp_rx.size(), 0);

    spi_begin(); spi_bits(8'hE7, 5, g, ea, en); spi_end();
    check(exp_rx.size() == 0, "R3 partial dropped", exp_rx.size(), 0);
    spi_begin(); write_byte(8'h3C, 1); write_byte(8'hC3, 0); spi_end();

    spi_begin(); write_byte(8'h81, 1);
    read_byte(8'hFF); read_byte(8'hAA); read_byte(8'h0F);
    check(!underrun, "R8 no underrun when loaded", underrun, 0);
    spi_end();
    check(!sdo_en, "R4 released after cs rise", sdo_en, 0);

    starve = 1;
    spi_begin(); write_byte(8'h90, 1);
    wait_clk(2);
    check(tx_req, "R7 request while empty", tx_req, 1);
    read_byte(8'h55); read_byte(8'hFF);
    spi_end();
    check(underrun, "R8 underrun sticky", underrun, 1);
    starve = 0;

    spi_begin();
    check(!underrun, "R8 cleared by cs fall", underrun, 0);
    write_byte(8'h01, 1); spi_end();
    check(exp_rx.size() == 0, "R6 no extra bytes", exp_rx.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule